// File: doc/BRIEF.md
# Pattern-Match Event Qualifier

This block decides, on every qualified system clock, whether downstream test operations (bus capture, trace writes, signature updates) should run. The monitored bus is compared against an expected word under a per-bit ignore mask. Both words are read from 16-entry register files at a shared pattern pointer. That pointer steps forward after every local match while a protocol is active, so a sequence of patterns can be followed. Either this local match or an external event input serves as the event.

A small protocol engine turns the event stream into a test-enable output. Start/stop opens the enable window on one event and closes it on the next. Start/pause/resume toggles the enable on each event until a budget taken from a third register file is used up. Do-while enables operations on exactly the samples where the event holds. A loop counter sets how many passes are made. Run and end-of-test flags report progress, and a selector routes one internal status signal to a single event output. All configuration comes in on parallel ports and must be held steady during a run. The file write port must not be used while a run is active.

Top module: `evq_engine`

## Requirements
- R1: After reset, `test_en`, `run`, `eot`, `evt_out` and `pat_ptr` are all zero.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr` in the expected file when `wr_sel`=0, in the mask file when `wr_sel`=1 and in the budget file when `wr_sel`=2. `wr_sel`=3 changes no file.
- R3: The local match is true when every bus bit whose mask bit is 0 equals the expected word at `pat_ptr`. Bits whose mask bit is 1 are ignored. The match is registered on each sample with `qclk_en` high, whether or not a run is active.
- R4: `cfg_src`=1 takes `ext_evt` as the protocol event. `cfg_src`=0 takes the local match.
- R5: `go` with `cfg_proto`≠0 sets `run`=1 and clears `eot`, `test_en`, `pat_ptr`, the budget-file index and the budget use count. It loads `cfg_loops` as the number of extra passes. `go` with `cfg_proto`=0 has no effect.
- R6: With `cfg_proto`=1 (start/stop), an event with `test_en` low sets it. An event with `test_en` high clears it and ends one pass.
- R7: With `cfg_proto`=2 (start/pause/resume), each event toggles `test_en` and counts one use of the budget. The budget is the budget-file entry at the pass index, which starts at 0 and advances by one per pass; a value of 0 counts as 1. The event that reaches the budget forces `test_en` low, ends the pass and clears the use count.
- R8: With `cfg_proto`=3 (do-while), `test_en` follows the event on each qualified sample. A qualified sample with no event after one with an event ends a pass.
- R9: When a pass ends with no extra passes left, `run` falls and `eot` rises on the same edge and `test_en` goes low. Otherwise the extra-pass count decrements. `eot` holds until the next accepted `go`, and `run` and `eot` are never both high.
- R10: While `run` is high, each qualified sample with a local match advances `pat_ptr` by one, wrapping from 15 to 0.
- R11: A cycle with `qclk_en` low and no `go` changes none of `test_en`, `run`, `eot`, `pat_ptr` or the registered local match.
- R12: `evt_out` shows the registered local match when `cfg_stsel`=0, `run` when 1, `eot` when 2 and `test_en` when 3.
- R13: Every output is registered. `test_en` changes on the same clock edge that samples the qualifying event, and it is high only while `run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qclk_en | input | 1 | Qualified system clock enable; the bus is sampled when high |
| bus_in | input | 16 | Monitored bus |
| ext_evt | input | 1 | External event input |
| wr_en | input | 1 | Register file write strobe |
| wr_sel | input | 2 | File select: 0 expected, 1 mask, 2 budget |
| wr_addr | input | 4 | File entry |
| wr_data | input | 16 | Write data |
| cfg_proto | input | 2 | 0 off, 1 start/stop, 2 start/pause/resume, 3 do-while |
| cfg_src | input | 1 | Event source: 0 local match, 1 external |
| cfg_loops | input | 8 | Extra passes after the first |
| cfg_stsel | input | 2 | Status routed to `evt_out` |
| go | input | 1 | Arm the selected protocol |
| test_en | output | 1 | Test-operation enable |
| run | output | 1 | Protocol active |
| eot | output | 1 | Protocol completed |
| evt_out | output | 1 | Selected status signal |
| pat_ptr | output | 4 | Current expected/mask entry |

## Verification
A wrong pattern pointer or mask decode first shows as a wrong registered match on `evt_out`, one clock after the sample. Within a few qualified samples it also shows as a drifting `pat_ptr`. A wrong loop count or budget count is more delayed: it shows only at the pass boundary, as `eot` rising early or late or `test_en` toggling once too often. The bench compares every port against an arithmetic model after each clock edge, so an error is reported in the cycle it reaches a port.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [1:0] {
    PR_OFF = 2'd0,
    PR_SS  = 2'd1,
    PR_SPR = 2'd2,
    PR_DW  = 2'd3
  } proto_e;

  typedef enum logic [1:0] {
    ST_HIT  = 2'd0,
    ST_RUN  = 2'd1,
    ST_EOT  = 2'd2,
    ST_TEN  = 2'd3
  } stsel_e;

  localparam int FILE_EXP = 0;
  localparam int FILE_MSK = 1;
  localparam int FILE_CNT = 2;
  localparam int NFILES   = 3;
endpackage

// File: rtl/evq_regfile.sv
module evq_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R2: a write is visible at its entry on the following cycle
  p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/evq_match.sv
module evq_match #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] bus,
  input  logic [WIDTH-1:0] exp_word,
  input  logic [WIDTH-1:0] msk_word,
  input  logic             ext_evt,
  input  logic             src_ext,
  output logic             local_hit,
  output logic             event_sel
);
  logic [WIDTH-1:0] diff;

  always_comb begin
    diff      = (bus ^ exp_word) & ~msk_word;
    local_hit = (diff == '0);
    event_sel = src_ext ? ext_evt : local_hit;
  end

  // R4: the external source passes the input straight through
  always_comb begin
    if (src_ext) p_src_ext_r4: assert (event_sel == ext_evt);
  end
endmodule

// File: rtl/evq_proto.sv
module evq_proto
  import evq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 16,
  parameter int LOOP_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qclk_en,
  input  logic              go,
  input  proto_e            proto,
  input  logic [LOOP_W-1:0] loops,
  input  logic              ev,
  input  logic              local_hit,
  input  logic [WIDTH-1:0]  budget_word,
  output logic              test_en,
  output logic              run,
  output logic              eot,
  output logic [AW-1:0]     ptr,
  output logic [AW-1:0]     cptr
);
  logic              en_q, run_q, eot_q;
  logic [AW-1:0]     ptr_q, cptr_q;
  logic [LOOP_W-1:0] left_q;
  logic [WIDTH-1:0]  used_q;

  logic              en_d, run_d, eot_d;
  logic [AW-1:0]     ptr_d, cptr_d;
  logic [LOOP_W-1:0] left_d;
  logic [WIDTH-1:0]  used_d;

  logic              arm;
  logic              step;
  logic              pass_done;
  logic              budget_hit;
  logic [WIDTH:0]    budget_lim;
  logic [WIDTH:0]    used_inc;

  assign arm  = go && (proto != PR_OFF);
  assign step = qclk_en && run_q && !arm;

  always_comb begin
    budget_lim = (budget_word == '0) ? {{WIDTH{1'b0}}, 1'b1} : {1'b0, budget_word};
    used_inc   = {1'b0, used_q} + 1'b1;
    budget_hit = (used_inc >= budget_lim);
  end

  always_comb begin
    pass_done = 1'b0;
    if (step) begin
      unique case (proto)
        PR_SS:   pass_done = ev && en_q;
        PR_SPR:  pass_done = ev && budget_hit;
        PR_DW:   pass_done = en_q && !ev;
        default: pass_done = 1'b0;
      endcase
    end
  end

  always_comb begin
    en_d   = en_q;
    run_d  = run_q;
    eot_d  = eot_q;
    ptr_d  = ptr_q;
    cptr_d = cptr_q;
    left_d = left_q;
    used_d = used_q;
    if (arm) begin
      en_d   = 1'b0;
      run_d  = 1'b1;
      eot_d  = 1'b0;
      ptr_d  = '0;
      cptr_d = '0;
      left_d = loops;
      used_d = '0;
    end else if (step) begin
      if (local_hit) ptr_d = ptr_q + 1'b1;
      unique case (proto)
        PR_SS: begin
          if (ev) en_d = !en_q;
        end
        PR_SPR: begin
          if (ev) begin
            if (budget_hit) begin
              en_d   = 1'b0;
              used_d = '0;
            end else begin
              en_d   = !en_q;
              used_d = used_inc[WIDTH-1:0];
            end
          end
        end
        PR_DW: begin
          en_d = ev;
        end
        default: begin
          en_d = 1'b0;
        end
      endcase
      if (pass_done) begin
        if (left_q == '0) begin
          run_d = 1'b0;
          eot_d = 1'b1;
          en_d  = 1'b0;
        end else begin
          left_d = left_q - 1'b1;
          cptr_d = cptr_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      eot_q  <= 1'b0;
      ptr_q  <= '0;
      cptr_q <= '0;
      left_q <= '0;
      used_q <= '0;
    end else begin
      en_q   <= en_d;
      run_q  <= run_d;
      eot_q  <= eot_d;
      ptr_q  <= ptr_d;
      cptr_q <= cptr_d;
      left_q <= left_d;
      used_q <= used_d;
    end
  end

  assign test_en = en_q;
  assign run     = run_q;
  assign eot     = eot_q;
  assign ptr     = ptr_q;
  assign cptr    = cptr_q;

  p_en_in_run_r13: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |-> run);

  p_run_eot_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && eot));

  p_end_of_test_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eot) |-> $fell(run));

  p_go_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && proto != PR_OFF) |=> (run && !eot && !test_en && ptr == '0));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!qclk_en && !go) |=> ($stable(run) && $stable(eot) && $stable(test_en) && $stable(ptr)));

  p_dowhile_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && qclk_en && !go && proto == PR_DW && ev) |=> test_en);

  p_ss_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && qclk_en && !go && proto == PR_SS && ev && !test_en) |=> test_en);

  p_ptr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && qclk_en && !go && local_hit) |=> ptr == AW'($past(ptr) + 1'b1));
endmodule

// File: rtl/evq_engine.sv
module evq_engine
  import evq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 16,
  parameter int LOOP_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qclk_en,
  input  logic [WIDTH-1:0]  bus_in,
  input  logic              ext_evt,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [1:0]        cfg_proto,
  input  logic              cfg_src,
  input  logic [LOOP_W-1:0] cfg_loops,
  input  logic [1:0]        cfg_stsel,
  input  logic              go,
  output logic              test_en,
  output logic              run,
  output logic              eot,
  output logic              evt_out,
  output logic [AW-1:0]     pat_ptr
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic [WIDTH-1:0] file_rd [NFILES];
  logic [AW-1:0]    file_ra [NFILES];
  logic [AW-1:0]    cptr;
  logic             local_hit;
  logic             ev;
  logic             hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  for (genvar f = 0; f < NFILES; f++) begin : g_file
    assign file_ra[f] = (f == FILE_CNT) ? cptr : pat_ptr;
    evq_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_file (
      .clk   (clk),
      .rst_n (rst_core_n),
      .we    (wr_en && (wr_sel == 2'(f))),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (file_ra[f]),
      .rdata (file_rd[f])
    );
  end

  evq_match #(.WIDTH(WIDTH)) u_match (
    .bus       (bus_in),
    .exp_word  (file_rd[FILE_EXP]),
    .msk_word  (file_rd[FILE_MSK]),
    .ext_evt   (ext_evt),
    .src_ext   (cfg_src),
    .local_hit (local_hit),
    .event_sel (ev)
  );

  evq_proto #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LOOP_W(LOOP_W)) u_proto (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .qclk_en     (qclk_en),
    .go          (go),
    .proto       (proto_e'(cfg_proto)),
    .loops       (cfg_loops),
    .ev          (ev),
    .local_hit   (local_hit),
    .budget_word (file_rd[FILE_CNT]),
    .test_en     (test_en),
    .run         (run),
    .eot         (eot),
    .ptr         (pat_ptr),
    .cptr        (cptr)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  hit_q <= 1'b0;
    else if (qclk_en) hit_q <= local_hit;
  end

  always_comb begin
    unique case (stsel_e'(cfg_stsel))
      ST_HIT:  evt_out = hit_q;
      ST_RUN:  evt_out = run;
      ST_EOT:  evt_out = eot;
      default: evt_out = test_en;
    endcase
  end

  p_hit_hold_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    !qclk_en |=> $stable(hit_q));
endmodule

// File: tb/evq_engine_bench.sv
module evq_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        qclk_en, ext_evt, wr_en, cfg_src, go;
  logic [15:0] bus_in, wr_data;
  logic [1:0]  wr_sel, cfg_proto, cfg_stsel;
  logic [3:0]  wr_addr;
  logic [7:0]  cfg_loops;
  logic        test_en, run, eot, evt_out;
  logic [3:0]  pat_ptr;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_exp [16];
  logic [15:0] m_msk [16];
  logic [15:0] m_cnt [16];
  logic        m_run, m_eot, m_en, m_hit;
  logic [3:0]  m_ptr, m_cptr;
  logic [7:0]  m_left;
  logic [15:0] m_used;
  logic [15:0] lf = 16'hACE1;
  string       tag;

  always #2 clk = ~clk;

  evq_engine u_evq_engine (
    .clk(clk), .rst_n(rst_n), .qclk_en(qclk_en), .bus_in(bus_in), .ext_evt(ext_evt),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_proto(cfg_proto), .cfg_src(cfg_src), .cfg_loops(cfg_loops), .cfg_stsel(cfg_stsel),
    .go(go), .test_en(test_en), .run(run), .eot(eot), .evt_out(evt_out), .pat_ptr(pat_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic m_status();
    case (cfg_stsel)
      2'd0: return m_hit;
      2'd1: return m_run;
      2'd2: return m_eot;
      default: return m_en;
    endcase
  endfunction

  task automatic compare_all();
    chk({tag, " R13 test_en"}, test_en, m_en);
    chk({tag, " R9 run"}, run, m_run);
    chk({tag, " R9 eot"}, eot, m_eot);
    chk({tag, " R10 pat_ptr"}, pat_ptr, m_ptr);
    chk({tag, " R12 evt_out"}, evt_out, m_status());
  endtask

  task automatic lfsr_next();
    lf = lf[0] ? ((lf >> 1) ^ 16'hB400) : (lf >> 1);
  endtask

  // one clock: drive at the falling edge, predict, check just after the rising edge
  task automatic step(input logic [15:0] b, input logic e, input logic q, input logic g);
    logic hit, ev, done, n_en, n_run, n_eot;
    logic [3:0] n_ptr, n_cptr;
    logic [7:0] n_left;
    logic [15:0] n_used;
    logic [16:0] lim;
    @(negedge clk);
    bus_in = b; ext_evt = e; qclk_en = q; go = g; wr_en = 1'b0;
    hit = (((b ^ m_exp[m_ptr]) & ~m_msk[m_ptr]) == 16'h0);
    ev = cfg_src ? e : hit;
    n_en = m_en; n_run = m_run; n_eot = m_eot; n_ptr = m_ptr; n_cptr = m_cptr;
    n_left = m_left; n_used = m_used; done = 1'b0;
    lim = (m_cnt[m_cptr] == 16'h0) ? 17'd1 : {1'b0, m_cnt[m_cptr]};
    if (g && cfg_proto != 2'd0) begin
      n_en = 0; n_run = 1; n_eot = 0; n_ptr = 0; n_cptr = 0; n_left = cfg_loops; n_used = 0;
    end else if (q && m_run) begin
      if (hit) n_ptr = m_ptr + 4'd1;
      case (cfg_proto)
        2'd1: if (ev) begin n_en = !m_en; done = m_en; end
        2'd2: if (ev) begin
                if ({1'b0, m_used} + 17'd1 >= lim) begin n_en = 0; n_used = 0; done = 1; end
                else begin n_en = !m_en; n_used = m_used + 16'd1; end
              end
        2'd3: begin n_en = ev; done = m_en && !ev; end
        default: n_en = 0;
      endcase
      if (done) begin
        if (m_left == 8'd0) begin n_run = 0; n_eot = 1; n_en = 0; end
        else begin n_left = m_left - 8'd1; n_cptr = m_cptr + 4'd1; end
      end
    end
    @(posedge clk);
    #1;
    if (q) m_hit = hit;
    m_en = n_en; m_run = n_run; m_eot = n_eot; m_ptr = n_ptr; m_cptr = n_cptr;
    m_left = n_left; m_used = n_used;
    compare_all();
  endtask

  task automatic wr(input logic [1:0] s, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_addr = a; wr_data = d; qclk_en = 1'b0; go = 1'b0;
    @(posedge clk);
    #1;
    case (s)
      2'd0: m_exp[a] = d;
      2'd1: m_msk[a] = d;
      2'd2: m_cnt[a] = d;
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_case(input logic [1:0] p, input logic [7:0] l, input logic s,
                          input logic [1:0] st, input int nsteps);
    @(negedge clk);
    cfg_proto = p; cfg_loops = l; cfg_src = s; cfg_stsel = st;
    tag = (p == 2'd1) ? "R6" : (p == 2'd2) ? "R7" : "R8";
    if (s) tag = {tag, " R4"};
    step(16'h0, 1'b0, 1'b1, 1'b1);
    chk({tag, " R5 armed"}, {run, eot}, 2'b10);
    for (int i = 0; i < nsteps; i++) begin
      lfsr_next();
      step({14'h0, lf[1:0]}, lf[3], lf[5] | lf[6] | lf[7], 1'b0);
    end
  endtask

  initial begin : watchdog
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; qclk_en = 0; ext_evt = 0; wr_en = 0; wr_sel = 0; wr_addr = 0;
    wr_data = 0; cfg_proto = 0; cfg_src = 0; cfg_loops = 0; cfg_stsel = 0; go = 0;
    bus_in = 0;
    for (int i = 0; i < 16; i++) begin m_exp[i] = 0; m_msk[i] = 0; m_cnt[i] = 0; end
    m_run = 0; m_eot = 0; m_en = 0; m_hit = 0; m_ptr = 0; m_cptr = 0; m_left = 0; m_used = 0;
    tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset outputs", {test_en, run, eot, evt_out}, 4'b0000);
    chk("R1 reset pointer", pat_ptr, 4'h0);

    // R3: single-bit mismatch sweep, masked and unmasked, entry 0
    tag = "R3";
    wr(2'd0, 4'd0, 16'hA5C3);
    for (int i = 0; i < 16; i++) begin
      wr(2'd1, 4'd0, 16'h0);
      step(16'hA5C3 ^ (16'h1 << i), 1'b0, 1'b1, 1'b0);
      chk("R3 unmasked bit differs", evt_out, 1'b0);
      wr(2'd1, 4'd0, 16'h1 << i);
      step(16'hA5C3 ^ (16'h1 << i), 1'b0, 1'b1, 1'b0);
      chk("R3 masked bit ignored", evt_out, 1'b1);
      step(16'hA5C3 ^ (16'h3 << (i % 15)), 1'b0, 1'b1, 1'b0);
    end

    // R2: select 3 writes nothing; entry 0 still matches
    tag = "R2";
    wr(2'd1, 4'd0, 16'h0);
    wr(2'd3, 4'd0, 16'hFFFF);
    step(16'hA5C3, 1'b0, 1'b1, 1'b0);
    chk("R2 select 3 ignored", evt_out, 1'b1);
    step(16'hA5C2, 1'b0, 1'b1, 1'b0);
    chk("R2 mask still clear", evt_out, 1'b0);

    // R11: samples ignored while qclk_en is low
    tag = "R11";
    step(16'hA5C3, 1'b0, 1'b0, 1'b0);
    chk("R11 hit held", evt_out, 1'b0);

    // R5: go with protocol off is ignored
    tag = "R5";
    cfg_proto = 2'd0;
    step(16'h0, 1'b0, 1'b1, 1'b1);
    chk("R5 off ignores go", {run, eot}, 2'b00);

    // load small-alphabet patterns and budgets (budget 0 included)
    for (int a = 0; a < 16; a++) begin
      wr(2'd0, 4'(a), 16'(a % 4));
      wr(2'd1, 4'(a), 16'hFFFC);
      wr(2'd2, 4'(a), 16'(a % 4));
    end

    for (int p = 1; p < 4; p++)
      for (int l = 0; l < 3; l++)
        for (int s = 0; s < 2; s++)
          run_case(2'(p), 8'(l), 1'(s), 2'((p + l + s) % 4), 48);

    // R10: every sample matches, pointer wraps past 15
    for (int a = 0; a < 16; a++) wr(2'd1, 4'(a), 16'hFFFF);
    run_case(2'd3, 8'd0, 1'b0, 2'd3, 0);
    tag = "R10";
    for (int i = 0; i < 20; i++) step(16'h1234, 1'b0, 1'b1, 1'b0);
    chk("R10 wrap", pat_ptr, 4'd4);

    // R11: a running protocol frozen without qualified clocks
    tag = "R11";
    for (int i = 0; i < 6; i++) step(16'(i), 1'b1, 1'b0, 1'b0);
    chk("R11 frozen run", {run, test_en}, 2'b11);

    // R5: go mid-run restarts
    run_case(2'd1, 8'd1, 1'b1, 2'd1, 0);
    chk("R5 restart pointer", pat_ptr, 4'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule